// File: doc/BRIEF.md
# Serial Command Front End for a Quad 8-Bit Output-Register Bank

This block is the slave side of a synchronous serial link that controls four 8-bit output codes and a per-channel mute/shutdown state. A host lowers `cs_n`, clocks a 14-bit word in MSB first on rising `sclk` edges, and raises `cs_n` again. All serial inputs are resynchronised into the system clock `clk`, and the rising edges of `sclk` are detected in that domain. The host must therefore run `sclk` well below `clk`.

Every register has a volatile copy and a nonvolatile shadow. The volatile copy drives the outputs. The shadows are modelled as flip-flops. A store command writes a shadow after a programmable number of `clk` cycles, and `ready` is low for that whole time. A recall command copies one shadow into its volatile register. A read command drives the selected volatile register out on `sdo` during the data byte of the same word.

Top module: `dac_cmd_if`

## Requirements
- R1: A word is 14 bits, sampled on rising `sclk` while `cs_n` is low, MSB first. The bits are, in order: start bit (must be 1), op[1:0], sel[2:0], data[7:0]. With op=00, sel 0..3 loads data into channel sel (`ch_code[8*sel+:8]`), and sel=4 loads data into the mute/shutdown register. In that register, bit i mutes channel i (`ch_mute[i]`) and bit 4+i shuts channel i down (`ch_shdn[i]`).
- R2: A word whose start bit is 0 changes no register and no output.
- R3: If `cs_n` rises before the 14th bit, the partial word is discarded. No volatile or nonvolatile register changes, and a store that was begun releases `ready`.
- R4: With op=01, sel 0..3 saves the data byte into that channel's shadow. Sel=4 saves the present mute/shutdown register and ignores the data byte. The outputs stay unchanged.
- R5: For a store, `ready` goes low once the sixth bit has been received. It stays low until STORE_CYCLES `clk` cycles after the word completes, and only then is the shadow written.
- R6: With op=11, sel 0..3 copies that channel's shadow into its volatile register. The other channels and the data byte have no effect.
- R7: With op=11 and sel=4, the mute/shutdown shadow is copied into the mute/shutdown register.
- R8: With op=10 and sel 0..4, `sdo_oe` rises after the sixth bit. `sdo` then presents the selected volatile register, bit 7 first, and advances one bit on each following `sclk` rise.
- R9: After reset `sdo_oe` is low, and it rises only for a valid read. Sel values 5..7 are ignored for every op.
- R10: While `cs_n` is high, `sclk` has no effect and `sdo`/`sdo_oe` hold their values. `sdo_oe` clears when `cs_n` next falls.
- R11: A word that completes while a store is still in progress is rejected with no register change, and `drop_flag` is set. `drop_flag` stays set until reset.
- R12: Reset clears all codes, mute/shutdown bits, shadows and `drop_flag`, and leaves `ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad (low = high impedance) |
| ready | output | 1 | High when no store is pending or in progress |
| ch_code | output | 32 | Four 8-bit channel codes, channel 0 in bits 7:0 |
| ch_mute | output | 4 | Per-channel mute |
| ch_shdn | output | 4 | Per-channel shutdown |
| drop_flag | output | 1 | Sticky: a word arrived during a store |

## Verification
The hardest condition to reach is a complete word arriving while a store timer is still running. A store is issued, and the bench shifts a second word in at once, with STORE_CYCLES set longer than one full serial word. Shadow contents cannot be read at the ports, so each store is confirmed later by a recall and a check of the volatile code. An aborted store is confirmed the same way: the old shadow value must come back.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 3;
  localparam int OP_W   = 2;
  localparam int HDR_W  = 1 + OP_W + ADDR_W;
  localparam int WORD_W = HDR_W + DATA_W;

  typedef enum logic [OP_W-1:0] {
    OP_WRITE  = 2'b00,
    OP_STORE  = 2'b01,
    OP_READ   = 2'b10,
    OP_RECALL = 2'b11
  } op_e;

  typedef struct packed {
    logic              start;
    op_e               op;
    logic [ADDR_W-1:0] sel;
  } hdr_t;

  localparam logic [ADDR_W-1:0] SEL_MS = ADDR_W'(NUM_CH);

  function automatic hdr_t hdr_from_prefix(logic [HDR_W-1:0] p);
    return hdr_t'(p);
  endfunction

  function automatic hdr_t hdr_from_word(logic [WORD_W-1:0] w);
    return hdr_t'(w[WORD_W-1 -: HDR_W]);
  endfunction

  function automatic logic [DATA_W-1:0] data_from_word(logic [WORD_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  function automatic logic sel_valid(logic [ADDR_W-1:0] s);
    return s <= SEL_MS;
  endfunction

  function automatic logic sel_is_channel(logic [ADDR_W-1:0] s);
    return s < SEL_MS;
  endfunction
endpackage

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
  parameter int WORD_W      = 14,
  parameter int HDR_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic [WORD_W-1:0] shreg,
  output logic              hdr_stb,
  output logic              word_stb,
  output logic              abort_stb,
  output logic              shift_stb,
  output logic              cs_fall_stb,
  output logic              cs_high
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [SYNC_STAGES-1:0] sclk_q, cs_q, sdi_q;
  logic                   sclk_d, cs_d;
  logic [CNT_W-1:0]       cnt;

  logic sclk_s, cs_s, sdi_s, full, take;
  assign sclk_s  = sclk_q[SYNC_STAGES-1];
  assign cs_s    = cs_q[SYNC_STAGES-1];
  assign sdi_s   = sdi_q[SYNC_STAGES-1];
  assign full    = (cnt == CNT_W'(WORD_W));
  assign take    = sclk_s & ~sclk_d & ~cs_s & ~full;
  assign cs_high = cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= '0;
      cs_q        <= '1;
      sdi_q       <= '0;
      sclk_d      <= 1'b0;
      cs_d        <= 1'b1;
      cnt         <= '0;
      shreg       <= '0;
      hdr_stb     <= 1'b0;
      word_stb    <= 1'b0;
      abort_stb   <= 1'b0;
      shift_stb   <= 1'b0;
      cs_fall_stb <= 1'b0;
    end else begin
      sclk_q      <= {sclk_q[SYNC_STAGES-2:0], sclk};
      cs_q        <= {cs_q[SYNC_STAGES-2:0], cs_n};
      sdi_q       <= {sdi_q[SYNC_STAGES-2:0], sdi};
      sclk_d      <= sclk_s;
      cs_d        <= cs_s;
      hdr_stb     <= take && (cnt == CNT_W'(HDR_W - 1));
      word_stb    <= take && (cnt == CNT_W'(WORD_W - 1));
      shift_stb   <= take;
      abort_stb   <= cs_s && !cs_d && (cnt != '0) && !full;
      cs_fall_stb <= !cs_s && cs_d;
      if (cs_s) begin
        cnt <= '0;
      end else if (take) begin
        cnt   <= cnt + CNT_W'(1);
        shreg <= {shreg[WORD_W-2:0], sdi_s};
      end
    end
  end
endmodule

// File: rtl/dac_nv_timer.sv
module dac_nv_timer #(
  parameter int unsigned STORE_CYCLES = 650000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(STORE_CYCLES + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(STORE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vol_we,
  input  logic [ADDR_W-1:0]        vol_sel,
  input  logic [DATA_W-1:0]        vol_data,
  input  logic                     rcl_en,
  input  logic [ADDR_W-1:0]        rcl_sel,
  input  logic                     nv_we,
  input  logic [ADDR_W-1:0]        nv_sel,
  input  logic [DATA_W-1:0]        nv_data,
  input  logic [ADDR_W-1:0]        rd_sel,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NUM_CH*DATA_W-1:0] ch_code,
  output logic [DATA_W-1:0]        ms_state
);
  localparam logic [ADDR_W-1:0] MS_SEL = ADDR_W'(NUM_CH);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DATA_W-1:0] vol_q, nv_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vol_q <= '0;
        nv_q  <= '0;
      end else begin
        if (vol_we && vol_sel == ADDR_W'(g))      vol_q <= vol_data;
        else if (rcl_en && rcl_sel == ADDR_W'(g)) vol_q <= nv_q;
        if (nv_we && nv_sel == ADDR_W'(g))        nv_q  <= nv_data;
      end
    end
    assign ch_code[g*DATA_W +: DATA_W] = vol_q;
  end

  logic [DATA_W-1:0] ms_nv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_state <= '0;
      ms_nv    <= '0;
    end else begin
      if (vol_we && vol_sel == MS_SEL)      ms_state <= vol_data;
      else if (rcl_en && rcl_sel == MS_SEL) ms_state <= ms_nv;
      if (nv_we && nv_sel == MS_SEL)        ms_nv    <= nv_data;
    end
  end

  always_comb begin
    rd_data = ms_state;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_sel == ADDR_W'(i)) rd_data = ch_code[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/dac_sdo_shift.sv
module dac_sdo_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  input  logic              clear,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [DATA_W-1:0] sh;

  assign sdo = sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      sdo_oe <= 1'b0;
    end else if (load) begin
      sh     <= load_data;
      sdo_oe <= 1'b1;
    end else if (clear) begin
      sdo_oe <= 1'b0;
    end else if (shift && sdo_oe) begin
      sh <= {sh[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/dac_cmd_if.sv
module dac_cmd_if
  import dac_cmd_pkg::*;
#(
  parameter int unsigned STORE_CYCLES = 650000,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk,
  input  logic                     cs_n,
  input  logic                     sdi,
  output logic                     sdo,
  output logic                     sdo_oe,
  output logic                     ready,
  output logic [NUM_CH*DATA_W-1:0] ch_code,
  output logic [NUM_CH-1:0]        ch_mute,
  output logic [NUM_CH-1:0]        ch_shdn,
  output logic                     drop_flag
);
  logic [WORD_W-1:0] shreg;
  logic hdr_stb, word_stb, abort_stb, shift_stb, cs_fall_stb, cs_high;

  dac_serial_rx #(.WORD_W(WORD_W), .HDR_W(HDR_W), .SYNC_STAGES(SYNC_STAGES)) rx_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .shreg(shreg), .hdr_stb(hdr_stb), .word_stb(word_stb), .abort_stb(abort_stb),
    .shift_stb(shift_stb), .cs_fall_stb(cs_fall_stb), .cs_high(cs_high)
  );

  hdr_t              pre, wh;
  logic [DATA_W-1:0] wdata;
  assign pre   = hdr_from_prefix(shreg[HDR_W-1:0]);
  assign wh    = hdr_from_word(shreg);
  assign wdata = data_from_word(shreg);

  logic nv_busy, store_fire;
  logic hdr_store_go, rd_load, word_ok, accept, reject_stb, store_start;
  logic store_pend;

  assign hdr_store_go = hdr_stb && pre.start && pre.op == OP_STORE && sel_valid(pre.sel) && !nv_busy;
  assign rd_load      = hdr_stb && pre.start && pre.op == OP_READ  && sel_valid(pre.sel) && !nv_busy;
  assign word_ok      = word_stb && wh.start && sel_valid(wh.sel);
  assign reject_stb   = word_ok && nv_busy;
  assign accept       = word_ok && !nv_busy;
  assign store_start  = accept && wh.op == OP_STORE;

  logic [DATA_W-1:0] ms_state, rd_data, st_data;
  logic [ADDR_W-1:0] st_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_pend <= 1'b0;
      drop_flag  <= 1'b0;
      st_sel     <= '0;
      st_data    <= '0;
    end else begin
      if (word_stb || abort_stb) store_pend <= 1'b0;
      else if (hdr_store_go)     store_pend <= 1'b1;
      if (reject_stb) drop_flag <= 1'b1;
      if (store_start) begin
        st_sel  <= wh.sel;
        st_data <= sel_is_channel(wh.sel) ? wdata : ms_state;
      end
    end
  end

  dac_nv_timer #(.STORE_CYCLES(STORE_CYCLES)) tmr_i (
    .clk(clk), .rst_n(rst_n), .start(store_start), .busy(nv_busy), .done(store_fire)
  );

  dac_reg_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .vol_we(accept && wh.op == OP_WRITE), .vol_sel(wh.sel), .vol_data(wdata),
    .rcl_en(accept && wh.op == OP_RECALL), .rcl_sel(wh.sel),
    .nv_we(store_fire), .nv_sel(st_sel), .nv_data(st_data),
    .rd_sel(pre.sel), .rd_data(rd_data),
    .ch_code(ch_code), .ms_state(ms_state)
  );

  dac_sdo_shift #(.DATA_W(DATA_W)) sdo_i (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .load_data(rd_data),
    .shift(shift_stb), .clear(cs_fall_stb), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  assign ready   = !(store_pend || nv_busy);
  assign ch_mute = ms_state[NUM_CH-1:0];
  assign ch_shdn = ms_state[2*NUM_CH-1:NUM_CH];
endmodule

// File: rtl/dac_cmd_if_chk.sv
module dac_cmd_if_chk #(
  parameter int CODE_W = 32,
  parameter int MS_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              sdo,
  input logic              sdo_oe,
  input logic [CODE_W-1:0] ch_code,
  input logic [MS_W-1:0]   ms_state,
  input logic              drop_flag,
  input logic              cs_high,
  input logic              store_fire,
  input logic              rd_load,
  input logic              reject_stb,
  input logic              abort_stb
);
  // R5
  store_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire |-> !ready);

  // R4
  store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire |=> ($stable(ch_code) && $stable(ms_state)));

  // R3
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |=> ($stable(ch_code) && $stable(ms_state)));

  // R8
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(rd_load));

  // R10
  cs_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_high && $past(cs_high) && $past(cs_high, 2)) |->
      ($stable(sdo) && $stable(sdo_oe) && $stable(ch_code)));

  // R11
  drop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_stb |=> drop_flag);

  // R11
  drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_flag |=> drop_flag);
endmodule

bind dac_cmd_if dac_cmd_if_chk #(.CODE_W(32), .MS_W(8)) chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready), .sdo(sdo), .sdo_oe(sdo_oe),
  .ch_code(ch_code), .ms_state(ms_state), .drop_flag(drop_flag),
  .cs_high(cs_high), .store_fire(store_fire), .rd_load(rd_load),
  .reject_stb(reject_stb), .abort_stb(abort_stb)
);

// File: tb/dac_cmd_if_tb_top.sv
module dac_cmd_if_tb_top;
  localparam int STORE = 400;
  localparam int HALF  = 6;
  localparam int NVEC  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, ready, drop_flag;
  logic [31:0] ch_code;
  logic [3:0]  ch_mute, ch_shdn;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  dac_cmd_if #(.STORE_CYCLES(STORE), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .ready(ready), .ch_code(ch_code),
    .ch_mute(ch_mute), .ch_shdn(ch_shdn), .drop_flag(drop_flag)
  );

  // word(14) | expected ch_code(32) | expected {shdn,mute}(8)
  localparam logic [53:0] VEC [NVEC] = '{
    {1'b1, 2'b00, 3'd0, 8'h3C, 32'h0000_003C, 8'h00},  // R1 ch0
    {1'b1, 2'b00, 3'd2, 8'hA5, 32'h00A5_003C, 8'h00},  // R1 ch2
    {1'b1, 2'b00, 3'd4, 8'h81, 32'h00A5_003C, 8'h81},  // R1 mute/shutdown
    {1'b0, 2'b00, 3'd1, 8'hFF, 32'h00A5_003C, 8'h81},  // R2 bad start
    {1'b1, 2'b00, 3'd5, 8'h77, 32'h00A5_003C, 8'h81},  // R9 bad select
    {1'b1, 2'b00, 3'd3, 8'hFF, 32'hFFA5_003C, 8'h81},  // R1 ch3
    {1'b1, 2'b00, 3'd1, 8'h5A, 32'hFFA5_5A3C, 8'h81},  // R1 ch1
    {1'b1, 2'b11, 3'd1, 8'hFF, 32'hFFA5_003C, 8'h81}   // R6 recall zero shadow
  };

  function automatic logic [13:0] mk(logic [1:0] op, logic [2:0] s, logic [7:0] d);
    return {1'b1, op, s, d};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [13:0] w, input int nbits,
                      output logic [7:0] rd, output logic oe6, output logic rdy8);
    rd = '0; oe6 = 1'b0; rdy8 = 1'b1;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int e = 1; e <= nbits; e++) begin
      sdi = w[14-e];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
      if (e >= 6 && e <= 13) rd[13-e] = sdo;
      if (e == 6) oe6 = sdo_oe;
      if (e == 8) rdy8 = ready;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic send(logic [13:0] w);
    logic [7:0] rd; logic oe6, rdy8;
    xfer(w, 14, rd, oe6, rdy8);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic oe6, rdy8;
    logic hold_sdo;
    wait_clk(5);
    // R12 reset state
    check("R12 code", ch_code, 32'h0);
    check("R12 ms", {24'h0, ch_shdn, ch_mute}, 32'h0);
    check("R12 ready", {31'h0, ready}, 32'h1);
    check("R12 drop", {31'h0, drop_flag}, 32'h0);
    check("R9 oe reset", {31'h0, sdo_oe}, 32'h0);
    rst_n = 1'b1;
    wait_clk(5);

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][53:40]);
      check("R1 table code", ch_code, VEC[i][39:8]);
      check("R1 table ms", {24'h0, ch_shdn, ch_mute}, {24'h0, VEC[i][7:0]});
    end

    // R8 read channel 2
    xfer(mk(2'b10, 3'd2, 8'h00), 14, rd, oe6, rdy8);
    check("R8 read ch2", {24'h0, rd}, 32'hA5);
    check("R8 oe", {31'h0, oe6}, 32'h1);
    // R10 clocks with cs high are ignored
    hold_sdo = sdo;
    for (int k = 0; k < 6; k++) begin
      sdi = k[0]; wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    check("R10 oe hold", {31'h0, sdo_oe}, 32'h1);
    check("R10 sdo hold", {31'h0, sdo}, {31'h0, hold_sdo});
    check("R10 code hold", ch_code, 32'hFFA5_003C);
    cs_n = 1'b0; wait_clk(HALF);
    check("R10 oe clear", {31'h0, sdo_oe}, 32'h0);
    cs_n = 1'b1; wait_clk(2 * HALF);

    xfer(mk(2'b10, 3'd4, 8'h00), 14, rd, oe6, rdy8);
    check("R8 read ms", {24'h0, rd}, 32'h81);
    xfer(mk(2'b10, 3'd6, 8'h00), 14, rd, oe6, rdy8);
    check("R9 bad read sel", {31'h0, oe6}, 32'h0);

    // R4 / R5 store ch0
    xfer(mk(2'b01, 3'd0, 8'h11), 14, rd, oe6, rdy8);
    check("R5 ready low mid word", {31'h0, rdy8}, 32'h0);
    check("R5 ready low after word", {31'h0, ready}, 32'h0);
    check("R4 outputs kept", ch_code, 32'hFFA5_003C);
    wait_clk(STORE - 120);
    check("R5 still busy", {31'h0, ready}, 32'h0);
    wait_clk(150);
    check("R5 ready back", {31'h0, ready}, 32'h1);

    // R11 word during store
    send(mk(2'b01, 3'd1, 8'h22));
    send(mk(2'b00, 3'd3, 8'h00));
    check("R11 rejected", ch_code, 32'hFFA5_003C);
    check("R11 flag", {31'h0, drop_flag}, 32'h1);
    wait_clk(STORE);
    check("R11 ready", {31'h0, ready}, 32'h1);

    // R6 recall
    send(mk(2'b11, 3'd0, 8'h77));
    check("R6 recall ch0", ch_code, 32'hFFA5_0011);
    send(mk(2'b11, 3'd1, 8'h00));
    check("R6 recall ch1", ch_code, 32'hFFA5_2211);

    // R4 / R7 mute-shutdown store and recall
    send(mk(2'b00, 3'd4, 8'h42));
    send(mk(2'b01, 3'd4, 8'h00));
    wait_clk(STORE + 20);
    check("R4 ms kept", {24'h0, ch_shdn, ch_mute}, 32'h42);
    send(mk(2'b00, 3'd4, 8'h00));
    check("R1 ms cleared", {24'h0, ch_shdn, ch_mute}, 32'h00);
    send(mk(2'b11, 3'd4, 8'hFF));
    check("R7 recall ms", {24'h0, ch_shdn, ch_mute}, 32'h42);
    check("R7 codes kept", ch_code, 32'hFFA5_2211);

    // R3 aborted words
    xfer(mk(2'b00, 3'd2, 8'h00), 10, rd, oe6, rdy8);
    check("R3 abort write", ch_code, 32'hFFA5_2211);
    xfer(mk(2'b01, 3'd0, 8'h99), 9, rd, oe6, rdy8);
    check("R3 abort store ready", {31'h0, ready}, 32'h1);
    wait_clk(STORE + 20);
    send(mk(2'b00, 3'd0, 8'h00));
    check("R1 ch0 cleared", ch_code, 32'hFFA5_2200);
    send(mk(2'b11, 3'd0, 8'h00));
    check("R3 shadow kept", ch_code, 32'hFFA5_2211);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule